// File: doc/BRIEF.md
# Channel Buffer Partitioner and USB Packet Cutter

This block sits on the write side of a parallel-bus-to-USB bridge. A two-bit strap, captured once after reset, chooses between a single-channel simple FIFO protocol and a multi-channel protocol with one, two or four channels. The strap sets how the 16 KB of buffer is shared: each active channel gets a double buffer, and each half shrinks as the channel count grows.

The bus side delivers one 32-bit word per beat, tagged with a channel, a byte-enable mask and an end-of-transaction marker. For each channel the block counts bytes and cuts the stream into USB packets. A packet closes when it reaches the maximum packet size, or when the transaction ends. The block also tracks which half of the channel's double buffer is filling and swaps halves when a half is full or a transaction ends. Each closed packet leaves the block as one descriptor that gives the channel, the length and a short-packet flag. The block stores no payload data.

Top module: `pkt_partitioner`

## Requirements
- R1: The strap is captured on the first rising clock edge after `rst_n` rises. Later strap changes have no effect on `chan_cap` or `simple_mode` until the next reset.
- R2: `chan_cap` holds 13 bits per channel, with channel i at bits [13*i+12:13*i]. It gives the half-buffer size in bytes. Strap 00 or 01 gives 4096 on channel 0. Strap 10 gives 2048 on channels 0 and 1. Strap 11 gives 1024 on all four channels. An inactive channel reads 0, so twice the sum of all halves never exceeds 8192 per direction (16 KB in total).
- R3: The byte count of a beat is the number of set bits in `beat_be`, where bit k covers byte lane k. Only the final beat of a transaction may have fewer than four bytes.
- R4: When a channel's open packet reaches 1024 bytes, a descriptor with `pkt_len` 1024 and `pkt_short` 0 is issued.
- R5: On the last beat of a transaction, any remaining bytes are issued as one descriptor, with `pkt_short` set when the length is below 1024. If no bytes remain, nothing extra is issued. A 1024-byte transaction therefore yields exactly one descriptor, and a 1025-byte transaction yields 1024 followed by 1.
- R6: A descriptor appears on the clock edge that samples the beat which closes it, and `pkt_chan` equals that beat's channel.
- R7: A beat whose channel has a capacity of 0 under the captured mode is ignored. It issues no descriptor, changes no `chan_half` bit, and leaves the channel's state untouched.
- R8: Each channel's `chan_half` bit toggles when the bytes in its current half reach the half size, or at the end of a transaction that put bytes into that half. After a toggle, the new half starts empty.
- R9: `simple_mode` is 1 exactly when the captured strap is 00.
- R10: Channels are counted independently, so beats of different channels may interleave without affecting one another.
- R11: A beat presented in the capture cycle itself (the first edge after reset release) is ignored.
- R12: During reset, `pkt_valid` and every `chan_half` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 2 | Mode strap, captured once after reset |
| beat_valid | input | 1 | A write word is present this cycle |
| beat_chan | input | 2 | Channel of the word |
| beat_be | input | 4 | Byte-lane enables of the word |
| beat_last | input | 1 | Word ends its transaction |
| pkt_valid | output | 1 | Descriptor present |
| pkt_chan | output | 2 | Descriptor channel |
| pkt_len | output | 11 | Descriptor length in bytes |
| pkt_short | output | 1 | Length below the maximum packet size |
| chan_cap | output | 52 | Half-buffer size per channel |
| chan_half | output | 4 | Active half per channel |
| simple_mode | output | 1 | Simple FIFO protocol selected |

## Verification
A descriptor and the `chan_half` update belong to the same clock edge that samples the closing beat. `chan_cap` and `simple_mode` settle on the first edge after reset release. The bench drives each beat between edges and waits for the next rising edge. It then compares every output, 1 ns after that edge, with a behavioural model advanced by the same beat, so each result is checked in the cycle it falls due. On top of this per-edge comparison, each transaction is checked as a whole: its descriptor lengths must add up to the transaction length, and only its final descriptor may be short.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef enum logic [1:0] {
    STRAP_SIMPLE = 2'b00,
    STRAP_MC1    = 2'b01,
    STRAP_MC2    = 2'b10,
    STRAP_MC4    = 2'b11
  } strap_e;
endpackage

// File: rtl/pkt_mode_latch.sv
module pkt_mode_latch #(
  parameter int NCH      = 4,
  parameter int HALF_MAX = 4096,
  parameter int CAP_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap,
  output logic             armed,
  output logic             simple,
  output logic [NCH-1:0]   active,
  output logic [CAP_W-1:0] half_size
);
  import pkt_pkg::*;

  strap_e mode_q, mode_d;
  logic   armed_q, armed_d;

  always_comb begin
    armed_d = 1'b1;
    mode_d  = armed_q ? mode_q : strap_e'(strap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= STRAP_SIMPLE;
    end else begin
      armed_q <= armed_d;
      mode_q  <= mode_d;
    end
  end

  logic [2:0] nch_sel;
  always_comb begin
    case (mode_q)
      STRAP_MC2: begin nch_sel = 3'd2; half_size = CAP_W'(HALF_MAX / 2); end
      STRAP_MC4: begin nch_sel = 3'd4; half_size = CAP_W'(HALF_MAX / 4); end
      default:   begin nch_sel = 3'd1; half_size = CAP_W'(HALF_MAX);     end
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_act
    assign active[i] = armed_q && (i < int'(nch_sel));
  end

  assign armed  = armed_q;
  assign simple = armed_q && (mode_q == STRAP_SIMPLE);
endmodule

// File: rtl/pkt_chan_track.sv
module pkt_chan_track #(
  parameter int MAXPKT = 1024,
  parameter int LEN_W  = 11,
  parameter int CAP_W  = 13,
  parameter int BCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [BCNT_W-1:0] nbytes,
  input  logic              last,
  input  logic [CAP_W-1:0]  half_size,
  output logic              emit,
  output logic [LEN_W-1:0]  emit_len,
  output logic              half_sel
);
  logic [LEN_W-1:0] acc_q, acc_d, acc_sum;
  logic [CAP_W-1:0] fill_q, fill_d, fill_sum;
  logic             half_q, half_d;

  always_comb begin
    acc_sum  = acc_q + LEN_W'(nbytes);
    fill_sum = fill_q + CAP_W'(nbytes);
    emit     = hit && (acc_sum != '0) &&
               ((acc_sum == LEN_W'(MAXPKT)) || last);
    emit_len = acc_sum;
    acc_d    = acc_q;
    fill_d   = fill_q;
    half_d   = half_q;
    if (hit) begin
      acc_d = emit ? '0 : acc_sum;
      if ((fill_sum >= half_size) || (last && (fill_sum != '0))) begin
        fill_d = '0;
        half_d = ~half_q;
      end else begin
        fill_d = fill_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      half_q <= 1'b0;
    end else if (hit) begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      half_q <= half_d;
    end
  end

  assign half_sel = half_q;
endmodule

// File: rtl/pkt_partitioner.sv
module pkt_partitioner #(
  parameter int NCH       = 4,
  parameter int WBYTES    = 4,
  parameter int MAXPKT    = 1024,
  parameter int BUF_BYTES = 16384,
  localparam int CH_W     = $clog2(NCH),
  localparam int BCNT_W   = $clog2(WBYTES) + 1,
  localparam int LEN_W    = $clog2(MAXPKT) + 1,
  localparam int HALF_MAX = BUF_BYTES / 4,
  localparam int CAP_W    = $clog2(HALF_MAX) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_strap,
  input  logic               beat_valid,
  input  logic [CH_W-1:0]    beat_chan,
  input  logic [WBYTES-1:0]  beat_be,
  input  logic               beat_last,
  output logic               pkt_valid,
  output logic [CH_W-1:0]    pkt_chan,
  output logic [LEN_W-1:0]   pkt_len,
  output logic               pkt_short,
  output logic [NCH*CAP_W-1:0] chan_cap,
  output logic [NCH-1:0]     chan_half,
  output logic               simple_mode
);
  logic             armed;
  logic [NCH-1:0]   active;
  logic [CAP_W-1:0] half_size;

  pkt_mode_latch #(.NCH(NCH), .HALF_MAX(HALF_MAX), .CAP_W(CAP_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .strap(mode_strap), .armed(armed),
    .simple(simple_mode), .active(active), .half_size(half_size)
  );

  logic [BCNT_W-1:0] nbytes;
  always_comb begin
    nbytes = '0;
    for (int b = 0; b < WBYTES; b++) nbytes = nbytes + BCNT_W'(beat_be[b]);
  end

  logic [NCH-1:0]   hit, emit;
  logic [LEN_W-1:0] lens [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = beat_valid && armed && active[i] && (beat_chan == CH_W'(i));
    assign chan_cap[i*CAP_W +: CAP_W] = active[i] ? half_size : '0;
    pkt_chan_track #(.MAXPKT(MAXPKT), .LEN_W(LEN_W), .CAP_W(CAP_W),
                     .BCNT_W(BCNT_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .hit(hit[i]), .nbytes(nbytes),
      .last(beat_last), .half_size(half_size), .emit(emit[i]),
      .emit_len(lens[i]), .half_sel(chan_half[i])
    );
  end

  logic             val_d;
  logic [LEN_W-1:0] len_d;
  logic             short_d;
  always_comb begin
    val_d = |emit;
    len_d = '0;
    for (int i = 0; i < NCH; i++) if (emit[i]) len_d = lens[i];
    short_d = (len_d < LEN_W'(MAXPKT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pkt_valid <= 1'b0;
    else        pkt_valid <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_chan  <= '0;
      pkt_len   <= '0;
      pkt_short <= 1'b0;
    end else if (val_d) begin
      pkt_chan  <= beat_chan;
      pkt_len   <= len_d;
      pkt_short <= short_d;
    end
  end
endmodule

// File: rtl/pkt_partitioner_chk.sv
module pkt_partitioner_chk #(
  parameter int NCH    = 4,
  parameter int CH_W   = 2,
  parameter int LEN_W  = 11,
  parameter int CAP_W  = 13,
  parameter int MAXPKT = 1024
) (
  input logic               clk,
  input logic               rst_n,
  input logic               armed,
  input logic               beat_valid,
  input logic [CH_W-1:0]    beat_chan,
  input logic               pkt_valid,
  input logic [CH_W-1:0]    pkt_chan,
  input logic [LEN_W-1:0]   pkt_len,
  input logic               pkt_short,
  input logic [NCH*CAP_W-1:0] chan_cap,
  input logic [NCH-1:0]     chan_half
);
  // R1: capacity frozen once the strap is captured
  a_r1_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(chan_cap));
  // R6: descriptor follows a sampled beat of the same channel
  a_r6_desc_from_beat: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> ($past(beat_valid) && pkt_chan == $past(beat_chan)));
  // R4: lengths never exceed the packet size and are never zero
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0 && pkt_len <= LEN_W'(MAXPKT)));
  // R5: a packet not flagged short is a full one
  a_r5_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_short) |-> pkt_len == LEN_W'(MAXPKT));
  // R7: descriptors only for channels with capacity
  a_r7_active_only: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> chan_cap[pkt_chan*CAP_W +: CAP_W] != '0);
  // R8/R10: one beat moves at most one channel's half
  a_r8_one_swap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_half ^ $past(chan_half)) <= 1);
endmodule

bind pkt_partitioner pkt_partitioner_chk #(
  .NCH(NCH), .CH_W(CH_W), .LEN_W(LEN_W), .CAP_W(CAP_W), .MAXPKT(MAXPKT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .beat_valid(beat_valid),
  .beat_chan(beat_chan), .pkt_valid(pkt_valid), .pkt_chan(pkt_chan),
  .pkt_len(pkt_len), .pkt_short(pkt_short), .chan_cap(chan_cap),
  .chan_half(chan_half)
);

// File: tb/tb_pkt_partitioner.sv
`timescale 1ns/1ps
module tb_pkt_partitioner;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_strap;
  logic        beat_valid;
  logic [1:0]  beat_chan;
  logic [3:0]  beat_be;
  logic        beat_last;
  logic        pkt_valid;
  logic [1:0]  pkt_chan;
  logic [10:0] pkt_len;
  logic        pkt_short;
  logic [51:0] chan_cap;
  logic [3:0]  chan_half;
  logic        simple_mode;

  always #2 clk = ~clk;

  pkt_partitioner dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  int m_acc[4], m_fill[4], m_nch, m_half;
  bit m_hb[4];
  int tx_sum, tx_cnt, tx_badshort;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset(input logic [1:0] s);
    for (int i = 0; i < 4; i++) begin m_acc[i] = 0; m_fill[i] = 0; m_hb[i] = 0; end
    m_nch  = (s == 2'b10) ? 2 : (s == 2'b11) ? 4 : 1;
    m_half = 4096 / m_nch;
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 1'b0; mode_strap = s; beat_valid = 1'b0;
    beat_chan = '0; beat_be = '0; beat_last = 1'b0;
    #7;
    chk(pkt_valid == 1'b0, "R12 valid in reset", int'(pkt_valid), 0);
    chk(chan_half == 4'h0, "R12 half in reset", int'(chan_half), 0);
    @(negedge clk); rst_n = 1'b1;
    model_reset(s);
    @(posedge clk); #1;
  endtask

  task automatic check_caps(input string req);
    for (int i = 0; i < 4; i++) begin
      int exp = (i < m_nch) ? m_half : 0;
      chk(int'(chan_cap[i*13 +: 13]) == exp, req, int'(chan_cap[i*13 +: 13]), exp);
    end
  endtask

  // drive one beat; compare all outputs 1 ns after the sampling edge
  task automatic beat(input int ch, input logic [3:0] be, input bit last, input string req);
    int n; bit e_emit; int e_len;
    beat_valid = 1'b1; beat_chan = 2'(ch); beat_be = be; beat_last = last;
    n = $countones(be);
    e_emit = 0; e_len = 0;
    if (ch < m_nch) begin
      m_acc[ch] += n; m_fill[ch] += n;
      if (m_acc[ch] != 0 && (m_acc[ch] == 1024 || last)) begin
        e_emit = 1; e_len = m_acc[ch]; m_acc[ch] = 0;
      end
      if (m_fill[ch] >= m_half || (last && m_fill[ch] != 0)) begin
        m_fill[ch] = 0; m_hb[ch] = ~m_hb[ch];
      end
    end
    @(posedge clk); #1;
    beat_valid = 1'b0; beat_last = 1'b0;
    chk(pkt_valid == e_emit, {req, " R6 valid"}, int'(pkt_valid), int'(e_emit));
    if (e_emit && pkt_valid) begin
      chk(int'(pkt_len) == e_len, {req, " R4/R5 len"}, int'(pkt_len), e_len);
      chk(int'(pkt_chan) == ch, {req, " R6 chan"}, int'(pkt_chan), ch);
      chk(pkt_short == (e_len < 1024), {req, " R5 short"}, int'(pkt_short), int'(e_len < 1024));
    end
    for (int i = 0; i < 4; i++)
      chk(chan_half[i] == m_hb[i], {req, " R8 half"}, int'(chan_half[i]), int'(m_hb[i]));
    if (pkt_valid) begin
      tx_sum += int'(pkt_len); tx_cnt++;
      if (pkt_short && !last) tx_badshort++;
    end
  endtask

  task automatic txn(input int ch, input int len);
    int nb = (len + 3) / 4;
    tx_sum = 0; tx_cnt = 0; tx_badshort = 0;
    for (int k = 0; k < nb; k++) begin
      int rem = len - 4 * k;
      int by = (rem >= 4) ? 4 : rem;
      beat(ch, 4'((1 << by) - 1), k == nb - 1, "R3");
    end
    chk(tx_sum == len, "R5 length sum", tx_sum, len);
    chk(tx_cnt == (len + 1023) / 1024, "R4 packet count", tx_cnt, (len + 1023) / 1024);
    chk(tx_badshort == 0, "R5 short only last", tx_badshort, 0);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: beat in the capture cycle is ignored
    rst_n = 1'b0; mode_strap = 2'b11; beat_valid = 1'b0;
    beat_chan = '0; beat_be = '0; beat_last = 1'b0;
    #7;
    chk(pkt_valid == 1'b0, "R12 valid in reset", int'(pkt_valid), 0);
    @(negedge clk); rst_n = 1'b1; model_reset(2'b11);
    beat_valid = 1'b1; beat_be = 4'hF; beat_last = 1'b1;
    @(posedge clk); #1; beat_valid = 1'b0; beat_last = 1'b0;
    chk(pkt_valid == 1'b0, "R11 capture-cycle beat", int'(pkt_valid), 0);
    chk(chan_half == 4'h0, "R11 half untouched", int'(chan_half), 0);
    check_caps("R2 caps 4ch");
    chk(simple_mode == 1'b0, "R9 simple off", int'(simple_mode), 0);
    // R1: strap changes later have no effect
    mode_strap = 2'b00;
    repeat (3) @(posedge clk); #1;
    check_caps("R1 caps frozen");
    chk(simple_mode == 1'b0, "R1 simple frozen", int'(simple_mode), 0);
    // R10: interleaved channels
    for (int k = 0; k < 6; k++) begin
      beat(0, 4'hF, k == 5, "R10 ch0");
      beat(1, 4'hF, k == 5, "R10 ch1");
    end
    txn(2, 1025);
    txn(3, 1024);
    txn(1, 1);
    for (int t = 0; t < 3; t++) txn(int'($urandom_range(0, 3)), int'($urandom_range(1, 4096)));

    // R7: beat to a channel beyond the strapped count
    do_reset(2'b10);
    check_caps("R2 caps 2ch");
    beat(3, 4'hF, 1'b1, "R7 inactive chan");
    chk(chan_half[3] == 1'b0, "R7 half idle", int'(chan_half[3]), 0);
    txn(1, 4096);
    txn(0, 2049);
    for (int t = 0; t < 3; t++) txn(int'($urandom_range(0, 1)), int'($urandom_range(1, 4096)));

    do_reset(2'b01);
    check_caps("R2 caps 1ch");
    chk(simple_mode == 1'b0, "R9 simple off mc1", int'(simple_mode), 0);
    beat(1, 4'hF, 1'b1, "R7 inactive chan mc1");
    txn(0, 4096);
    for (int t = 0; t < 3; t++) txn(0, int'($urandom_range(1, 4096)));

    do_reset(2'b00);
    check_caps("R2 caps simple");
    chk(simple_mode == 1'b1, "R9 simple on", int'(simple_mode), 1);
    txn(0, 3);
    for (int t = 0; t < 3; t++) txn(0, int'($urandom_range(1, 4096)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule